// File: doc/BRIEF.md
# Piecewise-Linear Sigmoid Activation Unit

This unit turns a signed fixed-point neuron sum into a bounded, odd-symmetric, S-shaped output that follows a hyperbolic tangent. The curve is made of straight pieces, each half a unit wide on the input axis. The first piece has slope one, and every following piece has half the slope of the one before it. Because each slope is a power of two, every piece is a constant shift plus an offset. A one-hot piece decoder and an AND-OR merge select the result, so the unit needs no multiplier and no table. The parameter `SEGS` sets how many sloped pieces come before the curve clips to full scale. This shapes how sharp the knee is near the rails.

Before the curve is applied, the sum is shifted left by a per-layer amount `post_shift`. This undoes the power-of-two pre-scaling that was applied offline to the weights and biases. When `linear_mode` is high, the scaled sum goes straight to the output unbounded, for a linear output layer. The unit is purely combinational. Its stream handshake is a wire pass-through: `out_valid` mirrors `in_valid` and `in_ready` mirrors `out_ready`. Nothing is held inside, so while `in_ready` is low the producer must keep `acc_in`, `post_shift` and `linear_mode` stable. A beat transfers on the downstream side when `out_valid` and `out_ready` are both high.

With the default parameters:
- `acc_in` is 12 bits with 7 fraction bits.
- The scaled sum `z` is 15 bits with 7 fraction bits.
- The activation code is 8 bits with 7 fraction bits.
- `y_word` carries either the scaled sum or the activation code, sign-extended and aligned to 7 fraction bits.

Top module: `pwl_sigmoid`

## Requirements
- R1: `out_valid` equals `in_valid` and `in_ready` equals `out_ready` at every instant, whatever the data inputs are.
- R2: The scaled sum is z = acc_in · 2^post_shift, exact in 15 bits, for post_shift 0 to 3.
- R3: With `linear_mode` = 1, `y_word` equals z as a 15-bit two's complement value in units of 2^-7.
- R4: With `linear_mode` = 0, `y_word` is the 8-bit activation code sign-extended to 15 bits (units 2^-7), and it always lies in [-128, 127].
- R5: For 0 <= z < SEGS·64, with k = z div 64 and r = z mod 64, the code is (128 - (128 >> k)) + (r >> k).
- R6: z = 0 gives code 0, and the code never decreases as z increases.
- R7: For z >= SEGS·64 (384 by default), the code is the largest positive value, 127.
- R8: For -SEGS·64 < z < 0, the code is the negation of the code for -z.
- R9: For z <= -SEGS·64, including the most negative z = -16384, the code is the most negative value, -128.
- R10: For every 12-bit input at post_shift = 0, the code/128 is within 0.05 of tanh(z/128).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| in_valid | input | 1 | Upstream beat present |
| in_ready | output | 1 | Unit can take a beat (mirror of out_ready) |
| acc_in | input | 12 | Signed neuron sum, 7 fraction bits |
| post_shift | input | 2 | Left-shift amount that undoes weight pre-scaling |
| linear_mode | input | 1 | 1 = pass scaled sum, 0 = apply curve |
| out_valid | output | 1 | Result present (mirror of in_valid) |
| out_ready | input | 1 | Downstream accepts the result |
| y_word | output | 15 | Signed result, 7 fraction bits |

## Verification
The post-scale shift and the curve's saturation can meet on one input. A small sum such as 48 becomes 384 after a shift of 3 and must clip to 127. The bench drives such sums at every shift value and compares the result against a model that applies the shift first and the curve second. Bypass and saturation are also provoked together: the most negative sum at the largest shift is sent with `linear_mode` high. The bench requires the full -16384 at the output instead of the clipped -128. That result shows bypass takes priority over the curve. A stalled handshake with changing data is also driven, and the bench checks that the valid and ready mirrors do not move.

// File: rtl/pwl_pkg.sv
package pwl_pkg;

  typedef enum logic {
    PATH_CURVE  = 1'b0,
    PATH_LINEAR = 1'b1
  } path_e;

  function automatic int ext_width(input int in_w, input int sh_max);
    return in_w + sh_max;
  endfunction

  function automatic int sel_width(input int sh_max);
    return (sh_max < 2) ? 1 : $clog2(sh_max + 1);
  endfunction

endpackage

// File: rtl/pwl_prescale.sv
module pwl_prescale #(
  parameter int IN_W   = 12,
  parameter int SH_MAX = 3,
  parameter int SH_W   = 2,
  parameter int EXT_W  = 15
) (
  input  logic [IN_W-1:0]  acc,
  input  logic [SH_W-1:0]  sh,
  output logic [EXT_W-1:0] z
);
  logic [SH_W-1:0] sh_eff;
  logic [SH_W:0][EXT_W-1:0] stg;

  // amounts beyond the supported range are clamped
  assign sh_eff = (sh > SH_W'(SH_MAX)) ? SH_W'(SH_MAX) : sh;
  assign stg[0] = {{(EXT_W-IN_W){acc[IN_W-1]}}, acc};

  // logarithmic barrel shifter, one stage per select bit
  for (genvar i = 0; i < SH_W; i++) begin : g_stage
    assign stg[i+1] = sh_eff[i] ? (stg[i] << (2**i)) : stg[i];
  end

  assign z = stg[SH_W];
endmodule

// File: rtl/pwl_fold.sv
module pwl_fold #(
  parameter int EXT_W = 15
) (
  input  logic [EXT_W-1:0] z,
  output logic [EXT_W-1:0] mag,
  output logic             neg
);
  localparam logic [EXT_W-1:0] UNIT = EXT_W'(1);

  assign neg = z[EXT_W-1];
  // magnitude is unsigned, so the most negative value still fits
  assign mag = neg ? (~z + UNIT) : z;
endmodule

// File: rtl/pwl_segment.sv
module pwl_segment #(
  parameter int EXT_W = 15,
  parameter int FRAC  = 7,
  parameter int SEGS  = 6
) (
  input  logic [EXT_W-1:0] mag,
  output logic [FRAC:0]    pos_val,
  output logic             sat
);
  localparam int KW = EXT_W - (FRAC - 1);
  localparam int VW = FRAC + 1;
  localparam logic [VW-1:0] ONE = VW'(1) << FRAC;

  logic [KW-1:0]           kidx;
  logic [FRAC-2:0]         rem;
  logic [SEGS-1:0]         hit;
  logic [SEGS-1:0][VW-1:0] lane;

  // each piece spans half a unit: 2^(FRAC-1) input codes
  assign kidx = mag[EXT_W-1:FRAC-1];
  assign rem  = mag[FRAC-2:0];
  assign sat  = (kidx >= KW'(SEGS));

  for (genvar k = 0; k < SEGS; k++) begin : g_lane
    localparam logic [VW-1:0] BASE = ONE - (ONE >> k);
    assign hit[k]  = (kidx == KW'(k));
    assign lane[k] = BASE + ({2'b00, rem} >> k);
  end

  always_comb begin
    pos_val = '0;
    for (int k = 0; k < SEGS; k++) begin
      pos_val = pos_val | (lane[k] & {VW{hit[k]}});
    end
  end
endmodule

// File: rtl/pwl_unfold.sv
module pwl_unfold #(
  parameter int FRAC  = 7,
  parameter int OUT_W = 8
) (
  input  logic [FRAC:0]    pos_val,
  input  logic             sat,
  input  logic             neg,
  output logic [OUT_W-1:0] code
);
  localparam int OUT_FRAC = OUT_W - 1;
  localparam int DROP = FRAC - OUT_FRAC;
  localparam logic [OUT_W-1:0] CODE_MAX = {1'b0, {OUT_FRAC{1'b1}}};
  localparam logic [OUT_W-1:0] CODE_MIN = {1'b1, {OUT_FRAC{1'b0}}};

  logic [OUT_W-1:0] pos_code;

  assign pos_code = pos_val[FRAC:DROP];

  always_comb begin
    if (sat)      code = neg ? CODE_MIN : CODE_MAX;
    else if (neg) code = ~pos_code + OUT_W'(1);
    else          code = pos_code;
  end
endmodule

// File: rtl/pwl_sigmoid.sv
module pwl_sigmoid #(
  parameter int IN_W   = 12,
  parameter int FRAC   = 7,
  parameter int OUT_W  = 8,
  parameter int SH_MAX = 3,
  parameter int SEGS   = 6,
  localparam int SH_W  = pwl_pkg::sel_width(SH_MAX),
  localparam int EXT_W = pwl_pkg::ext_width(IN_W, SH_MAX)
) (
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [IN_W-1:0]  acc_in,
  input  logic [SH_W-1:0]  post_shift,
  input  logic             linear_mode,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [EXT_W-1:0] y_word
);
  import pwl_pkg::*;

  localparam int DROP = FRAC - (OUT_W - 1);

  logic [EXT_W-1:0] z;
  logic [EXT_W-1:0] mag;
  logic             neg;
  logic [FRAC:0]    pos_val;
  logic             sat;
  logic [OUT_W-1:0] code;
  logic [EXT_W-1:0] act_ext;
  path_e            path;

  assign out_valid = in_valid;
  assign in_ready  = out_ready;

  pwl_prescale #(.IN_W(IN_W), .SH_MAX(SH_MAX), .SH_W(SH_W), .EXT_W(EXT_W)) u_pre (
    .acc(acc_in), .sh(post_shift), .z(z)
  );

  pwl_fold #(.EXT_W(EXT_W)) u_fold (.z(z), .mag(mag), .neg(neg));

  pwl_segment #(.EXT_W(EXT_W), .FRAC(FRAC), .SEGS(SEGS)) u_seg (
    .mag(mag), .pos_val(pos_val), .sat(sat)
  );

  pwl_unfold #(.FRAC(FRAC), .OUT_W(OUT_W)) u_unf (
    .pos_val(pos_val), .sat(sat), .neg(neg), .code(code)
  );

  assign act_ext = {{(EXT_W-OUT_W){code[OUT_W-1]}}, code} << DROP;
  assign path    = path_e'(linear_mode);
  assign y_word  = (path == PATH_LINEAR) ? z : act_ext;
endmodule

// File: rtl/pwl_sigmoid_chk.sv
module pwl_sigmoid_chk #(
  parameter int IN_W   = 12,
  parameter int FRAC   = 7,
  parameter int OUT_W  = 8,
  parameter int SH_MAX = 3,
  parameter int SEGS   = 6,
  parameter int SH_W   = 2,
  parameter int EXT_W  = 15
) (
  input logic             in_valid,
  input logic             in_ready,
  input logic [IN_W-1:0]  acc_in,
  input logic [SH_W-1:0]  post_shift,
  input logic             linear_mode,
  input logic             out_valid,
  input logic             out_ready,
  input logic [EXT_W-1:0] y_word
);
  localparam int DROP    = FRAC - (OUT_W - 1);
  localparam int ACT_MAX = ((2**(OUT_W-1)) - 1) * (2**DROP);
  localparam int ACT_MIN = -((2**(OUT_W-1)) * (2**DROP));
  localparam int LIMIT   = SEGS * (2**(FRAC-1));

  int zc;
  int yv;

  always_comb begin
    zc = int'($signed(acc_in)) * (2**int'(post_shift));
    yv = int'($signed(y_word));
    if (int'(post_shift) <= SH_MAX) begin
      if (linear_mode) begin
        // R3
        bypass_chk: assert (yv == zc) else $error("bypass mismatch");
      end else begin
        // R4
        range_chk: assert (yv >= ACT_MIN && yv <= ACT_MAX) else $error("curve out of range");
        // R8
        sign_chk: assert ((zc > 0 && yv >= 0) || (zc < 0 && yv <= 0) || (zc == 0 && yv == 0))
          else $error("curve sign wrong");
        // R7
        pos_sat_chk: assert (zc < LIMIT || yv == ACT_MAX) else $error("positive clip wrong");
        // R9
        neg_sat_chk: assert (zc > -LIMIT || yv == ACT_MIN) else $error("negative clip wrong");
      end
    end
  end
endmodule

bind pwl_sigmoid pwl_sigmoid_chk #(
  .IN_W(IN_W), .FRAC(FRAC), .OUT_W(OUT_W), .SH_MAX(SH_MAX),
  .SEGS(SEGS), .SH_W(SH_W), .EXT_W(EXT_W)
) u_chk (.*);

// File: tb/tb_pwl_sigmoid.sv
module tb_pwl_sigmoid;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 16;

  // acc, shift, linear, expected y_word
  localparam int VA[NV] = '{0, 32, 64, 100, 200, 383, 384, -100, -384, -383,
                            2047, -2048, 25, 48, -2048, 100};
  localparam int VS[NV] = '{0, 0, 0, 0, 0, 0, 0, 0, 0, 0,
                            3, 3, 2, 3, 3, 1};
  localparam int VL[NV] = '{0, 0, 0, 0, 0, 0, 0, 0, 0, 0,
                            0, 0, 0, 0, 1, 1};
  localparam int VE[NV] = '{0, 32, 64, 82, 113, 125, 127, -82, -128, -125,
                            127, -128, 82, 127, -16384, 200};

  logic clk = 0;
  logic rst_n = 0;
  logic in_valid, in_ready, linear_mode, out_valid, out_ready;
  logic [11:0] acc_in;
  logic [1:0]  post_shift;
  logic [14:0] y_word;
  int total = 0;
  int bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwl_sigmoid dut (
    .in_valid(in_valid), .in_ready(in_ready), .acc_in(acc_in),
    .post_shift(post_shift), .linear_mode(linear_mode),
    .out_valid(out_valid), .out_ready(out_ready), .y_word(y_word)
  );

  function automatic int model(input int z);
    int m, k, y;
    m = (z < 0) ? -z : z;
    k = m / 64;
    if (k >= 6) return (z < 0) ? -128 : 127;
    y = (128 - (128 >> k)) + ((m % 64) >> k);
    return (z < 0) ? -y : y;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic drive(input int a, input int s, input int l);
    acc_in = a[11:0];
    post_shift = s[1:0];
    linear_mode = l[0];
    #1;
  endtask

  initial begin
    int y, prev;
    real x, th, err;
    in_valid = 0; out_ready = 0; acc_in = '0; post_shift = '0; linear_mode = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // reset/idle state: zero input gives zero output and idle handshake (R6, R1)
    check("R6 idle y", int'($signed(y_word)), 0);
    check("R1 idle valid", int'(out_valid), 0);
    check("R1 idle ready", int'(in_ready), 0);
    rst_n = 1;

    // vector table walk (R2 R3 R5 R7 R8 R9)
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(VA[i], VS[i], VL[i]);
      check($sformatf("R5/R7/R8/R9/R2/R3 vec%0d", i), int'($signed(y_word)), VE[i]);
    end

    // handshake mirrors under stall with data changing (R1)
    @(negedge clk);
    in_valid = 1; out_ready = 0; drive(300, 1, 0);
    check("R1 valid mirror", int'(out_valid), 1);
    check("R1 stall ready", int'(in_ready), 0);
    drive(-7, 2, 1);
    check("R1 stall ready held", int'(in_ready), 0);
    in_valid = 0; out_ready = 1; #1;
    check("R1 valid low", int'(out_valid), 0);
    check("R1 ready mirror", int'(in_ready), 1);

    // exhaustive sweep against the bench model, all shifts (R2 R4 R5 R7 R8 R9)
    for (int s = 0; s < 4; s++) begin
      for (int a = -2048; a < 2048; a++) begin
        drive(a, s, 0);
        y = int'($signed(y_word));
        if (y != model(a * (2**s)))
          check($sformatf("R4/R5 sweep a=%0d s=%0d", a, s), y, model(a * (2**s)));
        else total++;
      end
    end

    // monotonic and tanh error bound, shift 0 (R6 R10)
    prev = -1000;
    for (int a = -2048; a < 2048; a++) begin
      drive(a, 0, 0);
      y = int'($signed(y_word));
      if (y < prev) check("R6 monotonic", y, prev);
      prev = y;
      x = real'(a) / 128.0;
      th = (1.0 - $exp(-2.0 * x)) / (1.0 + $exp(-2.0 * x));
      err = real'(y) / 128.0 - th;
      if (err < 0.0) err = -err;
      if (err > 0.05) check($sformatf("R10 tanh bound a=%0d", a), y, int'(th * 128.0));
    end
    total++;

    // linear bypass at full range, sweep of shift (R3)
    for (int s = 0; s < 4; s++) begin
      drive(2047, s, 1);
      check("R3 bypass max", int'($signed(y_word)), 2047 * (2**s));
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule